// File: doc/BRIEF.md
# Dual-Source Boot Image Selector

This block decides where the configuration image comes from after a power-on reset. It first waits for the open-drain init line to go high. It then asks an internal-load engine to bring the image in from on-chip non-volatile memory. If that attempt reports a CRC error, or gives no done indication within a fixed number of cycles, the block turns to a golden image held in an external serial flash. It issues a read request for that image, using the plain single-byte read command at a fixed start address.

A second failure, on the golden image, puts the block into a terminal failed state. In that state the attached slave devices are held safe until the next reset. The block reports its progress in two ways: a stage code shows which phase it is in, and a status code shows which path it settled on. A slave-hold output and a user-output enable tell the rest of the chip when pins may leave their safe or high-impedance state. The decoding of the bitstream, the flash device itself and the programming paths sit outside this block.

Top module: `boot_source_sel`

## Requirements
- R1: While reset is asserted and at the first cycle after it, boot_stage is 0 (waiting), boot_status is 00 (idle), slave_hold is 1, user_oe is 0, and both int_load_req and flash_rd_req are 0.
- R2: init_line passes through a two-flop synchroniser. int_load_req rises at the third rising clock edge after init_line goes high. Before that, the done and CRC inputs of both load paths have no effect.
- R3: The first load attempt always targets internal memory. int_load_req is 1 and flash_rd_req is 0, with boot_stage 1. The two requests are never high together.
- R4: If int_load_done is sampled high with int_load_crc_err low, the next cycle shows the primary result: boot_status 01, boot_stage 3, slave_hold 0 and user_oe 1.
- R5: If int_load_crc_err is sampled high during the internal attempt, the next cycle starts the external attempt, even when done is high in the same cycle.
- R6: With no response, int_load_req stays high for exactly DONE_TIMEOUT+1 cycles, and the external attempt then begins.
- R7: During the external attempt, flash_rd_req is 1, flash_rd_cmd is 0x03 and flash_rd_addr is GOLDEN_BASE (default 0x010000). In the same cycles boot_stage is 2, slave_hold is 1 and user_oe is 0.
- R8: The timeout counter restarts for the external attempt, so a silent flash attempt also lasts exactly DONE_TIMEOUT+1 cycles.
- R9: If ext_load_done is sampled high with ext_load_crc_err low, the next cycle shows the golden result: boot_status 10, boot_stage 3, user_oe 1, with slave_hold kept at 1.
- R10: An external CRC error or timeout leads to the failed result: boot_status 11, boot_stage 3, slave_hold 1, user_oe 0, with no request active.
- R11: Once boot_stage is 3, no input other than reset changes any output. This includes init_line falling.
- R12: A done without CRC error in the last cycle of the timeout window, cycle index DONE_TIMEOUT counted from 0, still counts as success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, standing for power-on reset |
| init_line | input | 1 | Asynchronous open-drain init level; high allows configuration to start |
| int_load_req | output | 1 | Request to the internal-load engine, held high for the attempt |
| int_load_done | input | 1 | Internal load finished |
| int_load_crc_err | input | 1 | Internal load saw a CRC error |
| flash_rd_req | output | 1 | External flash read request, held high for the attempt |
| flash_rd_cmd | output | 8 | Read command byte for the flash (0x03) |
| flash_rd_addr | output | ADDR_W | Start byte address of the golden image |
| ext_load_done | input | 1 | External load finished |
| ext_load_crc_err | input | 1 | External load saw a CRC error |
| boot_stage | output | 2 | 0 waiting, 1 internal load, 2 external load, 3 settled |
| boot_status | output | 2 | 00 idle, 01 primary, 10 golden, 11 failed |
| slave_hold | output | 1 | Keeps attached slave devices in their safe state |
| user_oe | output | 1 | Enable for general user outputs; low means tri-stated |

## Verification
The assertions take for granted three things about the inputs. The done and CRC inputs of a load path are only meaningful while that path's request is high. Reset is held for more than two cycles, so history reached through $past never predates reset. init_line is not expected to be metastable at the sampling flop, since the bench only drives it at falling clock edges. The stimulus drives every input on falling edges only, and applies a response only in the chosen cycle of the matching phase. It then clears all response inputs once the phase ends, apart from the explicit ignore tests before init and after settling.

// File: rtl/boot_sel_pkg.sv
package boot_sel_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_INIT,
    ST_INT_LOAD,
    ST_EXT_LOAD,
    ST_PRIMARY,
    ST_GOLDEN,
    ST_FAILED
  } boot_state_e;

  localparam logic [1:0] BS_IDLE    = 2'b00;
  localparam logic [1:0] BS_PRIMARY = 2'b01;
  localparam logic [1:0] BS_GOLDEN  = 2'b10;
  localparam logic [1:0] BS_FAILED  = 2'b11;

  localparam logic [1:0] STG_WAIT     = 2'd0;
  localparam logic [1:0] STG_INTERNAL = 2'd1;
  localparam logic [1:0] STG_EXTERNAL = 2'd2;
  localparam logic [1:0] STG_SETTLED  = 2'd3;

  localparam logic [7:0] FLASH_READ_CMD = 8'h03;

endpackage

// File: rtl/init_sync.sv
module init_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_in;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/load_timer.sv
module load_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  output logic expired
);

  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || start) begin
      cnt_q <= '0;
    end else if (run && (cnt_q != LIM)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expired = run && (cnt_q == LIM);

endmodule

// File: rtl/flash_req_gen.sv
module flash_req_gen
  import boot_sel_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE = ADDR_W'(24'h010000)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active_next,
  output logic              rd_req,
  output logic [7:0]        rd_cmd,
  output logic [ADDR_W-1:0] rd_addr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_req  <= 1'b0;
      rd_cmd  <= '0;
      rd_addr <= '0;
    end else begin
      rd_req  <= active_next;
      rd_cmd  <= active_next ? FLASH_READ_CMD : 8'h00;
      rd_addr <= active_next ? BASE : '0;
    end
  end

endmodule

// File: rtl/boot_source_sel.sv
module boot_source_sel
  import boot_sel_pkg::*;
#(
  parameter int DONE_TIMEOUT = 4096,
  parameter int ADDR_W       = 24,
  parameter logic [ADDR_W-1:0] GOLDEN_BASE = ADDR_W'(24'h010000),
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_line,
  output logic              int_load_req,
  input  logic              int_load_done,
  input  logic              int_load_crc_err,
  output logic              flash_rd_req,
  output logic [7:0]        flash_rd_cmd,
  output logic [ADDR_W-1:0] flash_rd_addr,
  input  logic              ext_load_done,
  input  logic              ext_load_crc_err,
  output logic [1:0]        boot_stage,
  output logic [1:0]        boot_status,
  output logic              slave_hold,
  output logic              user_oe
);

  boot_state_e state_q, state_d;
  logic init_s;
  logic in_load, start_load, expired;
  logic att_ok, att_fail;
  logic done_sel, crc_sel;

  logic       int_req_d, hold_d, oe_d;
  logic [1:0] stage_d, status_d;

  init_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (init_line),
    .sync_out (init_s)
  );

  assign in_load    = (state_q == ST_INT_LOAD) || (state_q == ST_EXT_LOAD);
  assign start_load = ((state_d == ST_INT_LOAD) || (state_d == ST_EXT_LOAD)) &&
                      (state_d != state_q);

  load_timer #(.LIMIT(DONE_TIMEOUT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (start_load),
    .run     (in_load),
    .expired (expired)
  );

  // Response of whichever source is currently being loaded.
  always_comb begin
    done_sel = 1'b0;
    crc_sel  = 1'b0;
    if (state_q == ST_INT_LOAD) begin
      done_sel = int_load_done;
      crc_sel  = int_load_crc_err;
    end else if (state_q == ST_EXT_LOAD) begin
      done_sel = ext_load_done;
      crc_sel  = ext_load_crc_err;
    end
  end

  assign att_ok   = done_sel && !crc_sel;
  assign att_fail = crc_sel || (!done_sel && expired);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_INIT: if (init_s) state_d = ST_INT_LOAD;
      ST_INT_LOAD: begin
        if (att_ok)        state_d = ST_PRIMARY;
        else if (att_fail) state_d = ST_EXT_LOAD;
      end
      ST_EXT_LOAD: begin
        if (att_ok)        state_d = ST_GOLDEN;
        else if (att_fail) state_d = ST_FAILED;
      end
      ST_PRIMARY, ST_GOLDEN, ST_FAILED: state_d = state_q;
      default: state_d = ST_FAILED;
    endcase
  end

  // Output decode of the next state, registered together with the state.
  always_comb begin
    int_req_d = 1'b0;
    hold_d    = 1'b1;
    oe_d      = 1'b0;
    stage_d   = STG_WAIT;
    status_d  = BS_IDLE;
    unique case (state_d)
      ST_WAIT_INIT: ;
      ST_INT_LOAD: begin
        int_req_d = 1'b1;
        stage_d   = STG_INTERNAL;
      end
      ST_EXT_LOAD: stage_d = STG_EXTERNAL;
      ST_PRIMARY: begin
        hold_d   = 1'b0;
        oe_d     = 1'b1;
        stage_d  = STG_SETTLED;
        status_d = BS_PRIMARY;
      end
      ST_GOLDEN: begin
        oe_d     = 1'b1;
        stage_d  = STG_SETTLED;
        status_d = BS_GOLDEN;
      end
      default: begin
        stage_d  = STG_SETTLED;
        status_d = BS_FAILED;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_WAIT_INIT;
      int_load_req <= 1'b0;
      slave_hold   <= 1'b1;
      user_oe      <= 1'b0;
      boot_stage   <= STG_WAIT;
      boot_status  <= BS_IDLE;
    end else begin
      state_q      <= state_d;
      int_load_req <= int_req_d;
      slave_hold   <= hold_d;
      user_oe      <= oe_d;
      boot_stage   <= stage_d;
      boot_status  <= status_d;
    end
  end

  flash_req_gen #(.ADDR_W(ADDR_W), .BASE(GOLDEN_BASE)) u_flash (
    .clk         (clk),
    .rst         (rst),
    .active_next (state_d == ST_EXT_LOAD),
    .rd_req      (flash_rd_req),
    .rd_cmd      (flash_rd_cmd),
    .rd_addr     (flash_rd_addr)
  );

endmodule

// File: rtl/boot_source_sel_chk.sv
module boot_source_sel_chk #(
  parameter int LIMIT  = 4096,
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] BASE = ADDR_W'(24'h010000)
) (
  input logic              clk,
  input logic              rst,
  input logic              init_line,
  input logic              int_load_req,
  input logic              flash_rd_req,
  input logic [7:0]        flash_rd_cmd,
  input logic [ADDR_W-1:0] flash_rd_addr,
  input logic [1:0]        boot_stage,
  input logic [1:0]        boot_status,
  input logic              slave_hold,
  input logic              user_oe
);

  logic [31:0] int_run, ext_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      int_run <= '0;
      ext_run <= '0;
    end else begin
      int_run <= int_load_req ? int_run + 1 : '0;
      ext_run <= flash_rd_req ? ext_run + 1 : '0;
    end
  end

  assert_wait_init_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(int_load_req) |-> $past(init_line, 2));

  assert_one_source_R3: assert property (@(posedge clk) disable iff (rst)
    !(int_load_req && flash_rd_req));

  assert_primary_release_R4: assert property (@(posedge clk) disable iff (rst)
    (boot_status == 2'b01) |-> (!slave_hold && user_oe && boot_stage == 2'd3));

  assert_int_window_R6: assert property (@(posedge clk) disable iff (rst)
    int_load_req |-> (int_run <= 32'(LIMIT)));

  assert_ext_read_R7: assert property (@(posedge clk) disable iff (rst)
    flash_rd_req |-> (flash_rd_cmd == 8'h03 && flash_rd_addr == BASE &&
                      slave_hold && !user_oe && boot_stage == 2'd2));

  assert_ext_window_R8: assert property (@(posedge clk) disable iff (rst)
    flash_rd_req |-> (ext_run <= 32'(LIMIT)));

  assert_golden_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (boot_status == 2'b10) |-> (slave_hold && user_oe));

  assert_failed_safe_R10: assert property (@(posedge clk) disable iff (rst)
    (boot_status == 2'b11) |-> (slave_hold && !user_oe && !int_load_req && !flash_rd_req));

  assert_settled_stable_R11: assert property (@(posedge clk) disable iff (rst)
    (boot_stage == 2'd3) |=> (boot_stage == 2'd3 && $stable(boot_status) &&
                             $stable(slave_hold) && $stable(user_oe)));

endmodule

bind boot_source_sel boot_source_sel_chk #(
  .LIMIT  (DONE_TIMEOUT),
  .ADDR_W (ADDR_W),
  .BASE   (GOLDEN_BASE)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .init_line     (init_line),
  .int_load_req  (int_load_req),
  .flash_rd_req  (flash_rd_req),
  .flash_rd_cmd  (flash_rd_cmd),
  .flash_rd_addr (flash_rd_addr),
  .boot_stage    (boot_stage),
  .boot_status   (boot_status),
  .slave_hold    (slave_hold),
  .user_oe       (user_oe)
);

// File: tb/boot_source_sel_test.sv
module boot_source_sel_test;

  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 6;
  localparam int ADDR_W     = 24;
  localparam logic [ADDR_W-1:0] BASE = 24'h010000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic init_line = 1'b0;
  logic int_load_done = 1'b0, int_load_crc_err = 1'b0;
  logic ext_load_done = 1'b0, ext_load_crc_err = 1'b0;
  logic int_load_req, flash_rd_req, slave_hold, user_oe;
  logic [7:0] flash_rd_cmd;
  logic [ADDR_W-1:0] flash_rd_addr;
  logic [1:0] boot_stage, boot_status;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_source_sel #(
    .DONE_TIMEOUT (LIMIT),
    .ADDR_W       (ADDR_W),
    .GOLDEN_BASE  (BASE)
  ) uut (
    .clk              (clk),
    .rst              (rst),
    .init_line        (init_line),
    .int_load_req     (int_load_req),
    .int_load_done    (int_load_done),
    .int_load_crc_err (int_load_crc_err),
    .flash_rd_req     (flash_rd_req),
    .flash_rd_cmd     (flash_rd_cmd),
    .flash_rd_addr    (flash_rd_addr),
    .ext_load_done    (ext_load_done),
    .ext_load_crc_err (ext_load_crc_err),
    .boot_stage       (boot_stage),
    .boot_status      (boot_status),
    .slave_hold       (slave_hold),
    .user_oe          (user_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_resp();
    int_load_done = 1'b0; int_load_crc_err = 1'b0;
    ext_load_done = 1'b0; ext_load_crc_err = 1'b0;
  endtask

  // Reset, pre-init ignore test, and init synchroniser latency.
  task automatic start_boot();
    @(negedge clk);
    rst = 1'b1; init_line = 1'b0; clear_resp();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 stage", {30'd0, boot_stage}, 0);
    chk("R1 status", {30'd0, boot_status}, 0);
    chk("R1 hold/oe/req", {28'd0, slave_hold, user_oe, int_load_req, flash_rd_req}, 32'b1000);
    int_load_done = 1'b1; int_load_crc_err = 1'b1; ext_load_done = 1'b1;
    repeat (2) @(negedge clk);
    clear_resp();
    chk("R2 ignored before init", {28'd0, boot_stage, int_load_req, flash_rd_req}, 0);
    init_line = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 no request after two edges", {31'd0, int_load_req}, 0);
    @(negedge clk);
    chk("R2 request at third edge", {31'd0, int_load_req}, 1);
    chk("R3 internal first", {29'd0, flash_rd_req, boot_stage}, 32'b001);
  endtask

  // Runs one load phase; kind bit0 = done, bit1 = crc error, applied in cycle k.
  task automatic run_phase(input bit is_ext, input int kind, input int k, output int len);
    bit active = 1'b1;
    len = 0;
    for (int g = 0; g < LIMIT + 4 && active; g++) begin
      active = is_ext ? flash_rd_req : int_load_req;
      if (active) begin
        if (is_ext && len == 0) begin
          chk("R7 cmd", {24'd0, flash_rd_cmd}, 32'h03);
          chk("R7 addr", {8'd0, flash_rd_addr}, {8'd0, BASE});
          chk("R7 hold/oe/stage", {28'd0, slave_hold, user_oe, boot_stage}, 32'b1010);
        end
        if (is_ext) begin
          ext_load_done    = (len == k) && kind[0];
          ext_load_crc_err = (len == k) && kind[1];
        end else begin
          int_load_done    = (len == k) && kind[0];
          int_load_crc_err = (len == k) && kind[1];
        end
        len++;
        @(negedge clk);
      end
    end
    clear_resp();
  endtask

  task automatic settle_ignore(input logic [1:0] exp_status);
    init_line = 1'b0;
    int_load_done = 1'b1; int_load_crc_err = 1'b1;
    ext_load_done = 1'b1; ext_load_crc_err = 1'b1;
    repeat (3) @(negedge clk);
    clear_resp();
    chk("R11 status held", {30'd0, boot_status}, {30'd0, exp_status});
    chk("R11 stage/req", {28'd0, boot_stage, int_load_req, flash_rd_req}, 32'b1100);
  endtask

  initial begin
    int len;
    bit int_ok, ext_ok;
    for (int ik = 0; ik < 4; ik++)
      for (int kk = 0; kk <= LIMIT + 1; kk++)
        for (int ek = 0; ek < 4; ek++)
          for (int ekk = 0; ekk <= LIMIT + 1; ekk++) begin
            int_ok = (ik == 1) && (kk <= LIMIT);
            if (int_ok && (ek != 0 || ekk != 0)) continue;
            if ((ik == 0 && kk != 0) || (ek == 0 && ekk != 0)) continue;
            start_boot();
            run_phase(1'b0, ik, kk, len);
            chk((ik == 0) ? "R6 internal window" : "R5 internal length", len,
                (ik != 0 && kk <= LIMIT) ? kk + 1 : LIMIT + 1);
            if (int_ok) begin
              chk((kk == LIMIT) ? "R12 late done primary" : "R4 primary status",
                  {30'd0, boot_status}, 32'b01);
              chk("R4 hold/oe/stage/flash", {27'd0, slave_hold, user_oe, boot_stage, flash_rd_req},
                  32'b01110);
              settle_ignore(2'b01);
            end else begin
              chk((ik[1]) ? "R5 switch to flash" : "R6 switch to flash",
                  {31'd0, flash_rd_req}, 1);
              run_phase(1'b1, ek, ekk, len);
              chk("R8 external length", len,
                  (ek != 0 && ekk <= LIMIT) ? ekk + 1 : LIMIT + 1);
              ext_ok = (ek == 1) && (ekk <= LIMIT);
              if (ext_ok) begin
                chk("R9 golden status", {30'd0, boot_status}, 32'b10);
                chk("R9 hold/oe/stage", {28'd0, slave_hold, user_oe, boot_stage}, 32'b1111);
                settle_ignore(2'b10);
              end else begin
                chk("R10 failed status", {30'd0, boot_status}, 32'b11);
                chk("R10 hold/oe/stage", {28'd0, slave_hold, user_oe, boot_stage}, 32'b1011);
                settle_ignore(2'b11);
              end
            end
          end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule